// File: doc/BRIEF.md
# Extended-Block Exit Predictor with Duration Countdown

This block sits in the front end of a processor that fetches whole extended basic blocks. When fetch starts a block it presents the block's start address. A small direct-mapped table answers with the address of the block expected to follow and the number of cycles the current block is expected to run. A down-counter loaded with that count tells decode on which cycle to end the current block and move to the predicted one. Fetch can therefore run ahead without waiting for the exit branch to be decoded.

When the block's exit resolves, the real target and cycle count are compared with the prediction. A wrong target, a wrong cycle count, or an exit taken with no prediction at all raises a flush. The flush is held for a fixed recovery penalty and carries the corrected fetch address. The first cycles of that window also kill the wrong-path bundles already issued. Every resolved exit updates the table entry.

Each entry also keeps a trip count and a running iteration count. This lets a short loop that exits after a fixed number of passes predict its final exit correctly once the count has been learned.

The controller is a five-state machine:
- `ST_IDLE` waits for a lookup.
- `ST_PRED` counts down a prediction.
- `ST_BLIND` waits for resolution after a table miss.
- `ST_HOLD` waits for resolution after the countdown has ended.
- `ST_RECOVER` drives the flush.

Its transitions are:
- lookup hit: `ST_IDLE` to `ST_PRED`.
- lookup miss: `ST_IDLE` to `ST_BLIND`.
- countdown end: `ST_PRED` to `ST_HOLD`.
- correct resolve: `ST_PRED`, `ST_BLIND` or `ST_HOLD` to `ST_IDLE`.
- wrong resolve: any of those three to `ST_RECOVER`.
- penalty done: `ST_RECOVER` to `ST_IDLE`.

Top module: `ebb_exit_predictor`

## Requirements
- R1: After reset every table entry is invalid, and `pred_valid`, `block_end`, `flush` and `kill_issue` are low.
- R2: A lookup accepted in idle whose entry is valid with a matching tag raises `pred_valid` from the next cycle, with `pred_target` and `pred_duration` from the entry. A lookup that misses leaves `pred_valid` low. `flush` and `pred_valid` are never high together.
- R3: With predicted duration d, `block_end` is high on exactly the d-th cycle after the lookup edge, provided no resolve arrives earlier. `pred_valid` then stays high until the exit resolves.
- R4: A resolve whose target and cycle count both equal the current prediction causes no flush, and the controller returns to idle on the next cycle.
- R5: A resolve that differs from the prediction in target or cycle count, or that arrives with no prediction, raises `flush` from the next cycle. `flush` stays high for exactly PENALTY (5) cycles, with `redirect_addr` equal to the resolved target and stable throughout.
- R6: `kill_issue` is high on the first SQUASH (2) cycles of each flush window and never outside it.
- R7: Resolve updates the entry for the block start address as follows:
  - On a miss, the entry is allocated with the resolved target and cycles, and the iteration count is set to 1.
  - When the resolve equals the stored primary target and cycles, the iteration count is incremented, saturating.
  - Otherwise, if the iteration count is nonzero, the resolve becomes the alternate exit, the trip count becomes the iteration count, the trip is marked learned, and the iteration count is cleared.
  - Otherwise, the primary is rewritten, the trip is marked unlearned, and the iteration count is set to 1.
- R8: A lookup predicts the alternate exit when the trip is learned and the iteration count equals the trip count. For a 3-pass self-loop, the second run of the loop raises no flush at all.
- R9: A lookup outside idle, and a resolve in idle or during recovery, have no effect on any output or on the table.
- R10: The table is direct-mapped: bits [3:0] of the address select the entry and bits [15:4] form the tag. Two addresses with the same index but different tags miss against each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A new block starts fetching |
| lookup_addr | input | 16 | Start address of that block |
| pred_valid | output | 1 | A prediction is held for the current block |
| pred_target | output | 16 | Predicted next block start address |
| pred_duration | output | 6 | Predicted block length in cycles |
| block_end | output | 1 | Decode ends the current block this cycle |
| resolve_valid | input | 1 | The current block's exit has resolved |
| resolve_target | input | 16 | Actual next block address |
| resolve_cycles | input | 6 | Actual block length in cycles |
| flush | output | 1 | Recovery window: stall and refetch |
| kill_issue | output | 1 | Squash wrong-path bundles already issued |
| redirect_addr | output | 16 | Corrected fetch address during flush |

## Verification
A lookup changes `pred_valid`, `pred_target` and `pred_duration` one edge later. `block_end` follows d edges after the lookup, and a resolve drives `flush`, `kill_issue` and `redirect_addr` one edge later, for five cycles. The bench keeps a behavioural model that is stepped right after each rising edge with the inputs sampled there. Every output is compared at the following falling edge, so each value is checked in the cycle it is due and never one cycle early or late. Targeted checks then count flush and kill cycles per window, and count the flushes during the trained loop pass.

// File: rtl/ebb_pred_pkg.sv
package ebb_pred_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRED,
        ST_BLIND,
        ST_HOLD,
        ST_RECOVER
    } pred_state_t;

    typedef enum logic [1:0] {
        UPD_ALLOC,
        UPD_STAY,
        UPD_EXIT,
        UPD_REPLACE
    } upd_kind_t;
endpackage

// File: rtl/ebb_exit_table.sv
module ebb_exit_table
    import ebb_pred_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DUR_W   = 6,
    parameter int ENTRIES = 16,
    parameter int TRIP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    output logic [DUR_W-1:0]  rd_duration,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic [DUR_W-1:0]  wr_cycles
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [TRIP_W-1:0] ITER_MAX = '1;

    logic              vld_q  [ENTRIES];
    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [ADDR_W-1:0] tgt_q  [ENTRIES];
    logic [DUR_W-1:0]  dur_q  [ENTRIES];
    logic [ADDR_W-1:0] alt_t_q[ENTRIES];
    logic [DUR_W-1:0]  alt_d_q[ENTRIES];
    logic [TRIP_W-1:0] trip_q [ENTRIES];
    logic              tok_q  [ENTRIES];
    logic [TRIP_W-1:0] iter_q [ENTRIES];

    logic [IDX_W-1:0] ri, wi;
    logic             use_alt, whit;
    upd_kind_t        kind;

    // read side: index, tag compare, last-pass selection
    always_comb begin
        ri        = rd_addr[IDX_W-1:0];
        rd_hit    = vld_q[ri] && (tag_q[ri] == rd_addr[ADDR_W-1:IDX_W]);
        use_alt   = tok_q[ri] && (iter_q[ri] == trip_q[ri]);
        rd_target   = use_alt ? alt_t_q[ri] : tgt_q[ri];
        rd_duration = use_alt ? alt_d_q[ri] : dur_q[ri];
    end

    // update classification (R7)
    always_comb begin
        wi   = wr_addr[IDX_W-1:0];
        whit = vld_q[wi] && (tag_q[wi] == wr_addr[ADDR_W-1:IDX_W]);
        if (!whit)
            kind = UPD_ALLOC;
        else if (tgt_q[wi] == wr_target && dur_q[wi] == wr_cycles)
            kind = UPD_STAY;
        else if (iter_q[wi] != '0)
            kind = UPD_EXIT;
        else
            kind = UPD_REPLACE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wi] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            unique case (kind)
                UPD_ALLOC, UPD_REPLACE: begin
                    tag_q[wi]  <= wr_addr[ADDR_W-1:IDX_W];
                    tgt_q[wi]  <= wr_target;
                    dur_q[wi]  <= wr_cycles;
                    tok_q[wi]  <= 1'b0;
                    iter_q[wi] <= TRIP_W'(1);
                end
                UPD_STAY: begin
                    if (iter_q[wi] != ITER_MAX) iter_q[wi] <= iter_q[wi] + 1'b1;
                end
                UPD_EXIT: begin
                    alt_t_q[wi] <= wr_target;
                    alt_d_q[wi] <= wr_cycles;
                    trip_q[wi]  <= iter_q[wi];
                    tok_q[wi]   <= 1'b1;
                    iter_q[wi]  <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ebb_exit_fsm.sv
module ebb_exit_fsm
    import ebb_pred_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DUR_W   = 6,
    parameter int PENALTY = 5,
    parameter int SQUASH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    input  logic              rd_hit,
    input  logic [ADDR_W-1:0] rd_target,
    input  logic [DUR_W-1:0]  rd_duration,
    input  logic              resolve_valid,
    input  logic [ADDR_W-1:0] resolve_target,
    input  logic [DUR_W-1:0]  resolve_cycles,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_target,
    output logic [DUR_W-1:0]  pred_duration,
    output logic              block_end,
    output logic              flush,
    output logic              kill_issue,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_addr
);
    localparam int RC_W = $clog2(PENALTY);

    pred_state_t       state_q, state_d;
    logic [DUR_W-1:0]  cnt_q;
    logic [RC_W-1:0]   rc_q;
    logic [ADDR_W-1:0] cur_q, ptgt_q, redir_q;
    logic [DUR_W-1:0]  pdur_q;
    logic              waiting, wrong;

    assign waiting = (state_q == ST_PRED) || (state_q == ST_BLIND) || (state_q == ST_HOLD);
    assign wrong   = (state_q == ST_BLIND) || (resolve_target != ptgt_q)
                  || (resolve_cycles != pdur_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (lookup_valid) state_d = rd_hit ? ST_PRED : ST_BLIND;
            ST_PRED:    if (resolve_valid) state_d = wrong ? ST_RECOVER : ST_IDLE;
                        else if (cnt_q <= DUR_W'(1)) state_d = ST_HOLD;
            ST_BLIND,
            ST_HOLD:    if (resolve_valid) state_d = wrong ? ST_RECOVER : ST_IDLE;
            ST_RECOVER: if (rc_q == RC_W'(PENALTY - 1)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rc_q    <= '0;
            cur_q   <= '0;
            ptgt_q  <= '0;
            pdur_q  <= '0;
            redir_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && lookup_valid) begin
                cur_q  <= lookup_addr;
                ptgt_q <= rd_target;
                pdur_q <= rd_duration;
                cnt_q  <= rd_duration;
            end else if (state_q == ST_PRED && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (waiting && resolve_valid && wrong) begin
                redir_q <= resolve_target;
                rc_q    <= '0;
            end else if (state_q == ST_RECOVER) begin
                rc_q <= rc_q + 1'b1;
            end
        end
    end

    always_comb begin
        pred_valid    = (state_q == ST_PRED) || (state_q == ST_HOLD);
        pred_target   = ptgt_q;
        pred_duration = pdur_q;
        block_end     = (state_q == ST_PRED) && (cnt_q <= DUR_W'(1));
        flush         = (state_q == ST_RECOVER);
        kill_issue    = (state_q == ST_RECOVER) && (rc_q < RC_W'(SQUASH));
        redirect_addr = redir_q;
        upd_en        = waiting && resolve_valid;
        upd_addr      = cur_q;
    end
endmodule

// File: rtl/ebb_exit_predictor.sv
module ebb_exit_predictor #(
    parameter int ADDR_W  = 16,
    parameter int DUR_W   = 6,
    parameter int ENTRIES = 16,
    parameter int TRIP_W  = 4,
    parameter int PENALTY = 5,
    parameter int SQUASH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_target,
    output logic [DUR_W-1:0]  pred_duration,
    output logic              block_end,
    input  logic              resolve_valid,
    input  logic [ADDR_W-1:0] resolve_target,
    input  logic [DUR_W-1:0]  resolve_cycles,
    output logic              flush,
    output logic              kill_issue,
    output logic [ADDR_W-1:0] redirect_addr
);
    logic              rd_hit, upd_en;
    logic [ADDR_W-1:0] rd_target, upd_addr;
    logic [DUR_W-1:0]  rd_duration;

    ebb_exit_table #(
        .ADDR_W(ADDR_W), .DUR_W(DUR_W), .ENTRIES(ENTRIES), .TRIP_W(TRIP_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(lookup_addr), .rd_hit(rd_hit),
        .rd_target(rd_target), .rd_duration(rd_duration),
        .wr_en(upd_en), .wr_addr(upd_addr),
        .wr_target(resolve_target), .wr_cycles(resolve_cycles)
    );

    ebb_exit_fsm #(
        .ADDR_W(ADDR_W), .DUR_W(DUR_W), .PENALTY(PENALTY), .SQUASH(SQUASH)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .rd_hit(rd_hit), .rd_target(rd_target), .rd_duration(rd_duration),
        .resolve_valid(resolve_valid), .resolve_target(resolve_target),
        .resolve_cycles(resolve_cycles),
        .pred_valid(pred_valid), .pred_target(pred_target),
        .pred_duration(pred_duration), .block_end(block_end),
        .flush(flush), .kill_issue(kill_issue), .redirect_addr(redirect_addr),
        .upd_en(upd_en), .upd_addr(upd_addr)
    );
endmodule

// File: rtl/ebb_exit_predictor_chk.sv
module ebb_exit_predictor_chk #(
    parameter int ADDR_W  = 16,
    parameter int DUR_W   = 6,
    parameter int PENALTY = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_valid,
    input logic [ADDR_W-1:0] pred_target,
    input logic [DUR_W-1:0]  pred_duration,
    input logic              block_end,
    input logic              resolve_valid,
    input logic [ADDR_W-1:0] resolve_target,
    input logic [DUR_W-1:0]  resolve_cycles,
    input logic              flush,
    input logic              kill_issue,
    input logic [ADDR_W-1:0] redirect_addr
);
    localparam int RUN_W = $clog2(PENALTY + 1) + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= flush ? run_q + 1'b1 : '0;
    end

    p_flush_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (run_q < RUN_W'(PENALTY)));
    p_flush_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush) |-> (run_q == RUN_W'(PENALTY)));
    p_redir_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && $past(flush)) |-> $stable(redirect_addr));
    p_wrong_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && pred_valid &&
         (resolve_target != pred_target || resolve_cycles != pred_duration))
        |=> (flush && redirect_addr == $past(resolve_target)));
    p_match_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && pred_valid &&
         resolve_target == pred_target && resolve_cycles == pred_duration)
        |=> (!flush && !pred_valid));
    p_kill_in_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_issue |-> flush);
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !pred_valid);
    p_end_has_pred_r3: assert property (@(posedge clk) disable iff (!rst_n)
        block_end |-> pred_valid);
endmodule

bind ebb_exit_predictor ebb_exit_predictor_chk #(
    .ADDR_W(ADDR_W), .DUR_W(DUR_W), .PENALTY(PENALTY)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_target(pred_target),
    .pred_duration(pred_duration), .block_end(block_end),
    .resolve_valid(resolve_valid), .resolve_target(resolve_target),
    .resolve_cycles(resolve_cycles), .flush(flush),
    .kill_issue(kill_issue), .redirect_addr(redirect_addr)
);

// File: tb/ebb_exit_predictor_test.sv
`timescale 1ns/1ps
module ebb_exit_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [15:0] lookup_addr = '0;
    logic        resolve_valid = 1'b0;
    logic [15:0] resolve_target = '0;
    logic [5:0]  resolve_cycles = '0;
    logic        pred_valid, block_end, flush, kill_issue;
    logic [15:0] pred_target, redirect_addr;
    logic [5:0]  pred_duration;

    int total = 0;
    int bad = 0;
    int fl_cnt = 0;
    int kill_cnt = 0;
    bit done = 0;

    // behavioural reference
    int ms, mcnt, mrec, mcur, mptg, mpdu, mredir;
    bit mv[16];
    int mtag[16], mtgt[16], mdur[16], malt_t[16], malt_d[16], mtrip[16], miter[16];
    bit mtok[16];

    always #5 clk = ~clk;

    ebb_exit_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .pred_valid(pred_valid), .pred_target(pred_target),
        .pred_duration(pred_duration), .block_end(block_end),
        .resolve_valid(resolve_valid), .resolve_target(resolve_target),
        .resolve_cycles(resolve_cycles), .flush(flush),
        .kill_issue(kill_issue), .redirect_addr(redirect_addr)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ms = 0; mcnt = 0; mrec = 0; mcur = 0; mptg = 0; mpdu = 0; mredir = 0;
        for (int i = 0; i < 16; i++) begin
            mv[i] = 0; mtok[i] = 0; miter[i] = 0;
        end
    endtask

    task automatic model_update(int a, int t, int c);
        int ix = a % 16;
        if (!(mv[ix] && mtag[ix] == a / 16)) begin
            mv[ix] = 1; mtag[ix] = a / 16; mtgt[ix] = t; mdur[ix] = c;
            mtok[ix] = 0; miter[ix] = 1;
        end else if (mtgt[ix] == t && mdur[ix] == c) begin
            if (miter[ix] < 15) miter[ix]++;
        end else if (miter[ix] != 0) begin
            malt_t[ix] = t; malt_d[ix] = c; mtrip[ix] = miter[ix];
            mtok[ix] = 1; miter[ix] = 0;
        end else begin
            mtgt[ix] = t; mdur[ix] = c; mtok[ix] = 0; miter[ix] = 1;
        end
    endtask

    task automatic model_step();
        case (ms)
            0: if (lookup_valid) begin
                int ix = lookup_addr % 16;
                mcur = lookup_addr;
                if (mv[ix] && mtag[ix] == lookup_addr / 16) begin
                    if (mtok[ix] && miter[ix] == mtrip[ix]) begin
                        mptg = malt_t[ix]; mpdu = malt_d[ix];
                    end else begin
                        mptg = mtgt[ix]; mpdu = mdur[ix];
                    end
                    mcnt = mpdu; ms = 1;
                end else ms = 2;
            end
            1, 2, 3: if (resolve_valid) begin
                bit wrong = (ms == 2) || resolve_target != mptg || resolve_cycles != mpdu;
                model_update(mcur, resolve_target, resolve_cycles);
                if (wrong) begin ms = 4; mrec = 0; mredir = resolve_target; end
                else ms = 0;
            end else if (ms == 1) begin
                if (mcnt <= 1) ms = 3; else mcnt--;
            end
            default: if (mrec == 4) ms = 0; else mrec++;
        endcase
    endtask

    task automatic compare_all();
        bit epv = (ms == 1 || ms == 3);
        check("R2 pred_valid", pred_valid, epv);
        if (epv) begin
            check("R2 pred_target", pred_target, mptg);
            check("R2 pred_duration", pred_duration, mpdu);
        end
        check("R3 block_end", block_end, (ms == 1 && mcnt <= 1));
        check("R5 flush", flush, ms == 4);
        check("R6 kill_issue", kill_issue, (ms == 4 && mrec < 2));
        check("R5 redirect_addr", redirect_addr, mredir);
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        if (rst_n) begin
            compare_all();
            if (flush) fl_cnt++;
            if (kill_issue) kill_cnt++;
        end
    endtask

    task automatic do_lookup(int a);
        lookup_valid = 1; lookup_addr = 16'(a);
        tick();
        lookup_valid = 0;
    endtask

    task automatic do_resolve(int t, int c);
        resolve_valid = 1; resolve_target = 16'(t); resolve_cycles = 6'(c);
        tick();
        resolve_valid = 0;
    endtask

    task automatic settle();
        for (int k = 0; k < 20 && ms != 0; k++) tick();
    endtask

    task automatic blk(int a, int t, int c, int gap);
        do_lookup(a);
        repeat (gap) tick();
        do_resolve(t, c);
        settle();
    endtask

    localparam int A = 16'h0105, B = 16'h0208, C = 16'h0300, ALIAS = 16'h1105;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pred_valid", pred_valid, 0);
        check("R1 flush", flush, 0);
        check("R1 block_end", block_end, 0);
        check("R1 kill_issue", kill_issue, 0);
        rst_n = 1;
        tick();

        // first pass of a 3-iteration loop: two flushes expected
        fl_cnt = 0;
        do_lookup(A);
        check("R2 miss no prediction", pred_valid, 0);
        tick();
        kill_cnt = 0;
        do_resolve(A, 4);
        settle();
        check("R6 kill cycles", kill_cnt, 2);
        blk(A, A, 4, 4);              // R3 countdown to HOLD, R4 match
        blk(A, B, 3, 2);              // early resolve, exit mispredicted
        check("R5 first pass flush cycles", fl_cnt, 10);
        blk(B, C, 6, 1);

        // second pass: trip count learned (R8)
        fl_cnt = 0;
        blk(A, A, 4, 4);
        blk(A, A, 4, 4);
        do_lookup(A);
        check("R8 last pass target", pred_target, B);
        check("R8 last pass duration", pred_duration, 3);
        repeat (3) tick();
        do_resolve(B, 3);
        settle();
        check("R8 no flush in trained pass", fl_cnt, 0);

        // duration-only mismatch (R5) and rewrite (R7)
        fl_cnt = 0;
        blk(A, A, 5, 4);
        check("R5 duration mismatch flush", fl_cnt, 5);
        do_lookup(A);
        check("R7 rewritten duration", pred_duration, 5);
        // R9: lookup while predicting is ignored
        lookup_valid = 1; lookup_addr = 16'(B);
        tick();
        lookup_valid = 0;
        check("R9 lookup ignored target", pred_target, A);
        check("R9 lookup ignored duration", pred_duration, 5);
        repeat (4) tick();
        check("R3 hold after countdown", pred_valid, 1);
        do_resolve(A, 5);
        settle();

        // R9: resolve in idle is ignored
        fl_cnt = 0;
        do_resolve(C, 9);
        repeat (3) tick();
        check("R9 idle resolve no flush", fl_cnt, 0);
        do_lookup(A);
        check("R9 table untouched", pred_duration, 5);
        tick();
        do_resolve(A, 5);
        settle();

        // R10: aliasing tag misses and replaces
        do_lookup(ALIAS);
        check("R10 alias miss", pred_valid, 0);
        do_resolve(C, 2);
        settle();
        do_lookup(A);
        check("R10 original now misses", pred_valid, 0);
        do_resolve(A, 4);
        settle();

        done = 1;
    end

    initial begin
        for (int w = 0; w < 5000 && !done; w++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule